// File: doc/BRIEF.md
# Performance Monitor Counter Update Controller

This block keeps a bank of running event counters and, on an update event, moves every running count into a holding register and clears the counters in the same clock. The holding registers keep their values until the next update, so software reads a consistent snapshot of one measurement interval while the next interval is already being counted.

A 2-bit mode input selects what causes an update. The first source is a software request bit that uses a level handshake. The second is an external pin, which is synchronized and edge-detected. The third is an internal prescaler that fires once per programmed period and stands in for a one-second timer. A status output tells software that a transfer has finished.

Top module: `pm_update_ctrl`

## Requirements
- R1: After reset all holding registers read 0, all running counters are 0 and `upd_status` is 0.
- R2: With `upd_mode` = 00, the clock edge that first sees `sw_upd` high after it was low copies every running counter into its holding register. Keeping `sw_upd` high does not cause a second copy.
- R3: The update clears every running counter in the same edge. An increment present in that cycle is counted into the cleared counter, so that counter holds 1 after the edge.
- R4: With `upd_mode` = 00, `upd_status` goes high on the edge that performs the update and stays high while `sw_upd` stays high.
- R5: With `upd_mode` = 00, the first edge that sees `sw_upd` low clears `upd_status`.
- R6: With `upd_mode` = 01, `ext_upd_pin` passes through a 2-flop synchronizer. A rising edge of the pin causes an update on the third clock edge after the pin rises. In this mode `sw_upd` has no effect.
- R7: With `upd_mode` = 10 or 11, an update happens every TICK_DIV clocks. The first update comes TICK_DIV clocks after this mode is entered, because the prescaler is held at 0 in the other modes.
- R8: In pin and timer modes, `upd_status` is high for exactly the one cycle after each update.
- R9: A running counter stops at 2^CNT_W-1 and does not wrap.
- R10: The holding registers do not change except on an update. Counter i occupies bits [i*CNT_W +: CNT_W] of `hold_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| evt_inc | input | NUM_CNT | One increment strobe per counter |
| upd_mode | input | 2 | 00 software bit, 01 external pin, 1x internal timer |
| sw_upd | input | 1 | Software update request bit, level handshake |
| ext_upd_pin | input | 1 | Asynchronous external update request |
| hold_flat | output | NUM_CNT*CNT_W | Packed holding registers, counter 0 in the low bits |
| upd_status | output | 1 | Update-complete status |

## Verification
Two situations are hard to reach from the ports: an increment that lands in the exact cycle of an update, and a counter that sits at its ceiling. For the first, the bench raises `sw_upd` and all increment strobes on the same falling edge, then reads the carried-over count back through a second update. For the second, a table entry holds one strobe high for 300 cycles, which drives an 8-bit counter past its limit before the update. Timer-mode alignment is checked by sampling status on the cycle before the TICK_DIV boundary and on the boundary cycle itself.

// File: rtl/pm_upd_pkg.sv
package pm_upd_pkg;

  typedef enum logic [1:0] {
    UPD_SW   = 2'b00,
    UPD_PIN  = 2'b01,
    UPD_TMR  = 2'b10,
    UPD_TMR2 = 2'b11
  } upd_mode_e;

  function automatic logic mode_is_sw(input logic [1:0] m);
    return m == UPD_SW;
  endfunction

  function automatic logic mode_is_timer(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/pm_upd_trigger.sv
module pm_upd_trigger
  import pm_upd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sw_upd,
  input  logic       ext_pin,
  output logic       latch,
  output logic       sw_rise,
  output logic       pin_rise,
  output logic       tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic                   sw_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic [PW-1:0]          pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q     <= 1'b0;
      sync_q   <= '0;
      pin_prev <= 1'b0;
    end else begin
      sw_q     <= sw_upd;
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      pin_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  // Prescaler runs only in timer mode and restarts from zero on entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!mode_is_timer(mode) || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign sw_rise  = sw_upd & ~sw_q;
  assign pin_rise = sync_q[SYNC_STAGES-1] & ~pin_prev;
  assign tick     = mode_is_timer(mode) && (pre_q == LAST);

  always_comb begin
    unique case (mode)
      UPD_SW:  latch = sw_rise;
      UPD_PIN: latch = pin_rise;
      default: latch = tick;
    endcase
  end

endmodule

// File: rtl/pm_cnt_bank.sv
module pm_cnt_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       inc,
  input  logic                     latch,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [NUM_CNT*CNT_W-1:0] hold_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // Next running value: restart on latch, otherwise saturating add.
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic             en,
                                                input logic             clr);
    if (clr)             return {{(CNT_W-1){1'b0}}, en};
    else if (!en)        return cur;
    else if (cur == CMAX) return cur;
    else                 return cur + 1'b1;
  endfunction

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        hold_q <= '0;
      end else begin
        run_q <= cnt_next(run_q, inc[i], latch);
        if (latch) hold_q <= run_q;
      end
    end

    assign cnt_flat[i*CNT_W +: CNT_W]  = run_q;
    assign hold_flat[i*CNT_W +: CNT_W] = hold_q;
  end

endmodule

// File: rtl/pm_upd_status.sv
module pm_upd_status
  import pm_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sw_upd,
  input  logic       latch,
  output logic       status
);
  // Software mode holds status until the request drops; other modes pulse.
  function automatic logic status_next(input logic cur, input logic lat,
                                       input logic sw_m, input logic req);
    if (lat)       return 1'b1;
    else if (sw_m) return cur & req;
    else           return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= status_next(status, latch, mode_is_sw(mode), sw_upd);
  end

endmodule

// File: rtl/pm_update_ctrl.sv
module pm_update_ctrl #(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 8,
  parameter int TICK_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       evt_inc,
  input  logic [1:0]               upd_mode,
  input  logic                     sw_upd,
  input  logic                     ext_upd_pin,
  output logic [NUM_CNT*CNT_W-1:0] hold_flat,
  output logic                     upd_status
);
  logic                     latch_evt;
  logic                     sw_rise;
  logic                     pin_rise;
  logic                     tmr_tick;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  pm_upd_trigger #(.SYNC_STAGES(SYNC_STAGES), .TICK_DIV(TICK_DIV)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode(upd_mode), .sw_upd(sw_upd),
    .ext_pin(ext_upd_pin), .latch(latch_evt), .sw_rise(sw_rise),
    .pin_rise(pin_rise), .tick(tmr_tick)
  );

  pm_cnt_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .inc(evt_inc), .latch(latch_evt),
    .cnt_flat(cnt_flat), .hold_flat(hold_flat)
  );

  pm_upd_status u_stat (
    .clk(clk), .rst_n(rst_n), .mode(upd_mode), .sw_upd(sw_upd),
    .latch(latch_evt), .status(upd_status)
  );

endmodule

// File: rtl/pm_update_ctrl_chk.sv
module pm_update_ctrl_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     latch_evt,
  input logic [1:0]               upd_mode,
  input logic                     sw_upd,
  input logic [NUM_CNT-1:0]       evt_inc,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT*CNT_W-1:0] hold_flat,
  input logic                     upd_status
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_hold_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> hold_flat == $past(cnt_flat));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(hold_flat));

  p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> upd_status);

  p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == 2'b00 && !sw_upd) |=> !upd_status);

  p_status_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode != 2'b00 && !latch_evt) |=> !upd_status);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_chk
    p_clear_on_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_evt |=> cnt_flat[i*CNT_W +: CNT_W] == CNT_W'($past(evt_inc[i])));

    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[i*CNT_W +: CNT_W] == CMAX && !latch_evt)
        |=> cnt_flat[i*CNT_W +: CNT_W] == CMAX);
  end

endmodule

bind pm_update_ctrl pm_update_ctrl_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .upd_mode(upd_mode),
  .sw_upd(sw_upd), .evt_inc(evt_inc), .cnt_flat(cnt_flat),
  .hold_flat(hold_flat), .upd_status(upd_status)
);

// File: tb/pm_update_ctrl_bench.sv
`timescale 1ns/1ps
module pm_update_ctrl_bench;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int TD = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   evt_inc = '0;
  logic [1:0]     upd_mode = 2'b00;
  logic           sw_upd = 1'b0;
  logic           ext_upd_pin = 1'b0;
  logic [N*W-1:0] hold_flat;
  logic           upd_status;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pm_update_ctrl #(.NUM_CNT(N), .CNT_W(W), .TICK_DIV(TD)) u_pm_update_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .upd_mode(upd_mode),
    .sw_upd(sw_upd), .ext_upd_pin(ext_upd_pin), .hold_flat(hold_flat),
    .upd_status(upd_status)
  );

  // {mask[3:0], cycles[9:0], exp3, exp2, exp1, exp0}
  localparam int NV = 5;
  localparam logic [45:0] VEC [NV] = '{
    {4'b0001, 10'd5,   8'd0,   8'd0,   8'd0,   8'd5},
    {4'b1111, 10'd3,   8'd3,   8'd3,   8'd3,   8'd3},
    {4'b0110, 10'd7,   8'd0,   8'd7,   8'd7,   8'd0},
    {4'b1000, 10'd300, 8'd255, 8'd0,   8'd0,   8'd0},
    {4'b0101, 10'd255, 8'd0,   8'd255, 8'd0,   8'd255}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hv(input int i);
    return int'(hold_flat[i*W +: W]);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 status", int'(upd_status), 0);
    for (int i = 0; i < N; i++) chk("R1 hold", hv(i), 0);
    rst_n = 1'b1;
    step(1);

    // Table: count, update by software handshake, check snapshot (R2 R4 R5 R9)
    for (int v = 0; v < NV; v++) begin
      evt_inc = VEC[v][45:42];
      step(int'(VEC[v][41:32]));
      evt_inc = '0;
      step(1);
      chk("R4 status before request", int'(upd_status), 0);
      sw_upd = 1'b1;
      step(1);
      chk("R4 status after update", int'(upd_status), 1);
      for (int i = 0; i < N; i++)
        chk("R2 R9 snapshot", hv(i), int'(VEC[v][i*8 +: 8]));
      step(2);
      chk("R4 status held", int'(upd_status), 1);
      sw_upd = 1'b0;
      step(1);
      chk("R5 status cleared", int'(upd_status), 0);
    end

    // R3 increment in the update cycle; R2 R10 no second copy while held
    evt_inc = '1;
    sw_upd  = 1'b1;
    step(1);
    for (int i = 0; i < N; i++) chk("R3 snapshot zero", hv(i), 0);
    evt_inc = 4'b0001;
    step(4);
    evt_inc = '0;
    step(1);
    for (int i = 0; i < N; i++) chk("R2 R10 no relatch", hv(i), 0);
    sw_upd = 1'b0;
    step(1);
    sw_upd = 1'b1;
    step(1);
    chk("R3 carry c0", hv(0), 5);
    for (int i = 1; i < N; i++) chk("R3 carry", hv(i), 1);
    sw_upd = 1'b0;
    step(1);

    // R6 pin mode, software bit ignored; R8 pulse
    upd_mode = 2'b01;
    evt_inc  = 4'b0010;
    step(6);
    evt_inc = '0;
    sw_upd  = 1'b1;
    step(2);
    chk("R6 sw ignored c0", hv(0), 5);
    chk("R6 sw ignored status", int'(upd_status), 0);
    sw_upd = 1'b0;
    step(1);
    ext_upd_pin = 1'b1;
    step(1);
    chk("R6 edge1 status", int'(upd_status), 0);
    step(1);
    chk("R6 edge2 status", int'(upd_status), 0);
    step(1);
    chk("R6 edge3 status", int'(upd_status), 1);
    chk("R6 c1", hv(1), 6);
    chk("R6 c0", hv(0), 0);
    step(1);
    chk("R8 pin pulse end", int'(upd_status), 0);
    step(3);
    chk("R8 pin level no repeat", int'(upd_status), 0);
    ext_upd_pin = 1'b0;
    step(4);

    // R7 timer mode, R8 pulse
    upd_mode = 2'b10;
    evt_inc  = 4'b0100;
    step(TD - 1);
    chk("R7 before period", int'(upd_status), 0);
    step(1);
    chk("R7 first tick status", int'(upd_status), 1);
    chk("R7 first tick c2", hv(2), TD - 1);
    step(1);
    chk("R8 timer pulse end", int'(upd_status), 0);
    step(TD - 2);
    chk("R7 before second", int'(upd_status), 0);
    step(1);
    chk("R7 second tick status", int'(upd_status), 1);
    chk("R7 second tick c2", hv(2), TD);
    evt_inc = '0;
    step(2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule